// File: doc/BRIEF.md
# Four-Channel Pulse Width Modulator Core

This core turns four 16-bit compare words into four pulse-width-modulated outputs that all run from a single shared counter. Each counter step is one prescaled tick. A tick comes every 2^`prescale_sel` clock cycles. The counter either runs as a sawtooth from 0 up to the top value, which gives edge-aligned pulses, or as a triangle up to the top value and back down, which gives center-aligned pulses. In each compare word the low 15 bits set the duty threshold and bit 15 inverts the output.

Pulse generation begins with a one-cycle `start` pulse. All configuration inputs are double-buffered: compare words, top value, counting mode and prescale code are captured when generation starts and again at every period boundary, and they stay frozen in between. A one-cycle `period_end` pulse marks every completed period. A `stop_req` pulse does not cut the current period short. The core finishes that period, then goes idle, and `stopped` pulses together with the final `period_end`. All inputs are plain level or pulse pins sampled on the rising clock edge, and none of them has back-pressure.

Top module: `quad_pwm_core`

## Requirements
- R1: After reset, all four outputs are 0, and `period_end` and `stopped` are 0.
- R2: The prescaled tick comes every 2^`prescale_sel` clock cycles, with `prescale_sel` from 0 to 7, so every period length below scales by that factor.
- R3: With `center_mode`=0 the counter steps 0,1,...,top and then wraps to 0, so a period is top+1 ticks. A channel is active while the counter is below its compare value (bits 14..0).
- R4: With `center_mode`=1 the counter steps 0 up to top and then back down to 1, so a period is 2×top ticks. A channel is active while the counter is below its compare value.
- R5: Bit 15 of a compare word inverts its output: output = active XOR bit 15.
- R6: A compare value of 0 keeps the channel inactive for the whole period. A compare value greater than or equal to top keeps it active for the whole period.
- R7: Changes to `cmp_words`, `top_value`, `center_mode` or `prescale_sel` made during a period take effect only from the next period boundary.
- R8: `period_end` is high for exactly the first clock cycle of each new period, which is the cycle after the boundary edge. It is never high while generation is idle.
- R9: After a `stop_req` pulse, the current period finishes, then generation stops. `stopped` and the final `period_end` pulse in the same cycle. While idle, each output holds the level its polarity bit gives, taken from the last compare word that was loaded.
- R10: A `stop_req` that arrives on the very edge that ends a period stops generation at that same boundary, and no new period starts.
- R11: `start` is ignored while generation is running, and `stop_req` is ignored while idle (no `stopped` pulse follows).
- R12: A top value of 0 gives a period of one tick in either counting mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins generation when idle |
| stop_req | input | 1 | One-cycle pulse that requests a stop at the end of the current period |
| prescale_sel | input | 3 | Tick divider code; the divide ratio is 2^code |
| center_mode | input | 1 | 0 = sawtooth (edge-aligned), 1 = triangle (center-aligned) |
| top_value | input | 15 | Counter top value |
| cmp_words | input | 64 | Four compare words; channel n is bits 16n+15..16n, and bit 16n+15 is its polarity |
| pwm_out | output | 4 | Channel outputs; bit n is channel n |
| period_end | output | 1 | One-cycle pulse at the start of each new period |
| stopped | output | 1 | One-cycle pulse when generation has halted |

## Verification
Three things can happen on the same clock edge: the end of a period, a reload of the shadow registers, and a stop request. The bench drives `stop_req` exactly on a boundary edge and checks that this edge produces both `period_end` and `stopped`, that no further period follows, and that the outputs then settle at their polarity levels. In a separate case, compare words and top are changed in the middle of a period. A cycle-by-cycle reference model then checks that the new values appear only from the following boundary.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;
  localparam int unsigned QP_CH    = 4;
  localparam int unsigned QP_CNT_W = 15;
  localparam int unsigned QP_PS_W  = 3;

  typedef enum logic { CNT_UP = 1'b0, CNT_DOWN = 1'b1 } cnt_dir_e;
endpackage

// File: rtl/qp_prescaler.sv
module qp_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;
  localparam logic [DIV_W-1:0] ONES = {DIV_W{1'b1}};

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  // limit = 2^sel - 1, built by shifting an all-ones vector
  assign limit = ONES >> (PS_W'(DIV_W) - sel);
  assign tick  = run && (div_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (!run || tick)  div_q <= '0;
    else                    div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/qp_counter.sv
module qp_counter
  import quad_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             center,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  cnt_dir_e         dir_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt + CNT_W'(1);

  always_comb begin
    if (center) last = (top == '0) || (dir_q == CNT_DOWN && cnt == CNT_W'(1));
    else        last = (cnt == top);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      dir_q <= CNT_UP;
    end else if (!run) begin
      cnt   <= '0;
      dir_q <= CNT_UP;
    end else if (tick) begin
      if (last) begin
        cnt   <= '0;
        dir_q <= CNT_UP;
      end else if (center && dir_q == CNT_DOWN) begin
        cnt <= cnt - CNT_W'(1);
      end else begin
        cnt <= cnt_inc;
        if (center && cnt_inc == top) dir_q <= CNT_DOWN;
      end
    end
  end
endmodule

// File: rtl/qp_channel.sv
module qp_channel #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             run,
  input  logic [CNT_W:0]   word,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] top,
  output logic             level
);
  logic [CNT_W-1:0] thresh;
  logic             invert;
  logic             active;

  assign thresh = word[CNT_W-1:0];
  assign invert = word[CNT_W];
  assign active = run && (thresh != '0) && ((thresh >= top) || (cnt < thresh));
  assign level  = active ^ invert;
endmodule

// File: rtl/quad_pwm_core.sv
module quad_pwm_core
  import quad_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = QP_CH,
  parameter int unsigned CNT_W  = QP_CNT_W,
  parameter int unsigned PS_W   = QP_PS_W,
  localparam int unsigned WORD_W = CNT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     stop_req,
  input  logic [PS_W-1:0]          prescale_sel,
  input  logic                     center_mode,
  input  logic [CNT_W-1:0]         top_value,
  input  logic [NUM_CH*WORD_W-1:0] cmp_words,
  output logic [NUM_CH-1:0]        pwm_out,
  output logic                     period_end,
  output logic                     stopped
);
  logic                     running_q;
  logic                     pend_q;
  logic [NUM_CH*WORD_W-1:0] sh_cmp;
  logic [CNT_W-1:0]         sh_top;
  logic                     sh_center;
  logic [PS_W-1:0]          sh_sel;
  logic                     tick;
  logic                     last;
  logic [CNT_W-1:0]         cnt;
  logic                     boundary;
  logic                     stop_now;
  logic                     load;

  assign boundary = tick && last;
  assign stop_now = pend_q || stop_req;
  assign load     = (!running_q && start) || (boundary && !stop_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q  <= 1'b0;
      pend_q     <= 1'b0;
      period_end <= 1'b0;
      stopped    <= 1'b0;
    end else begin
      period_end <= boundary;
      stopped    <= boundary && stop_now;
      if (!running_q) begin
        running_q <= start;
        pend_q    <= 1'b0;
      end else if (boundary && stop_now) begin
        running_q <= 1'b0;
        pend_q    <= 1'b0;
      end else begin
        pend_q    <= stop_now;
      end
    end
  end

  // shadow copies of the configuration, refreshed only at start or a boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_cmp    <= '0;
      sh_top    <= '0;
      sh_center <= 1'b0;
      sh_sel    <= '0;
    end else if (load) begin
      sh_cmp    <= cmp_words;
      sh_top    <= top_value;
      sh_center <= center_mode;
      sh_sel    <= prescale_sel;
    end
  end

  qp_prescaler #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(running_q), .sel(sh_sel), .tick(tick)
  );

  qp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(running_q), .tick(tick),
    .center(sh_center), .top(sh_top), .cnt(cnt), .last(last)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    qp_channel #(.CNT_W(CNT_W)) u_ch (
      .run(running_q), .word(sh_cmp[g*WORD_W +: WORD_W]),
      .cnt(cnt), .top(sh_top), .level(pwm_out[g])
    );
  end
endmodule

// File: rtl/quad_pwm_checker.sv
module quad_pwm_checker #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 15,
  localparam int unsigned WORD_W = CNT_W + 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     running,
  input logic [CNT_W-1:0]         cnt,
  input logic [CNT_W-1:0]         sh_top,
  input logic [NUM_CH*WORD_W-1:0] sh_cmp,
  input logic [NUM_CH-1:0]        pwm_out,
  input logic                     period_end,
  input logic                     stopped
);
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt <= sh_top);

  assert_stop_with_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> period_end);

  assert_stop_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> !stopped);

  assert_idle_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !$past(running)) |-> $stable(pwm_out));

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !period_end) |-> ($stable(sh_cmp) && $stable(sh_top)));

  assert_event_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> $past(running));
endmodule

bind quad_pwm_core quad_pwm_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running_q), .cnt(cnt), .sh_top(sh_top),
  .sh_cmp(sh_cmp), .pwm_out(pwm_out), .period_end(period_end), .stopped(stopped)
);

// File: tb/test_quad_pwm_core.sv
module test_quad_pwm_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        stop_req = 1'b0;
  logic [2:0]  prescale_sel = '0;
  logic        center_mode = 1'b0;
  logic [14:0] top_value = '0;
  logic [63:0] cmp_words = '0;
  logic [3:0]  pwm_out;
  logic        period_end;
  logic        stopped;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  bit          m_run = 1'b0;
  bit          m_pend = 1'b0;
  int          m_rel = 0;
  int          m_sel = 0;
  bit          m_ctr = 1'b0;
  int          m_top = 0;
  logic [63:0] m_words = '0;

  logic [5:0] q_val[$];
  string      q_tag[$];

  always #5 clk = ~clk;

  quad_pwm_core i_quad_pwm_core (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_req(stop_req),
    .prescale_sel(prescale_sel), .center_mode(center_mode), .top_value(top_value),
    .cmp_words(cmp_words), .pwm_out(pwm_out), .period_end(period_end), .stopped(stopped)
  );

  task automatic check(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got {stopped,period_end,out}=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_load();
    m_sel = prescale_sel; m_ctr = center_mode; m_top = top_value; m_words = cmp_words;
  endtask

  // period length in clock cycles (R2, R3, R4, R12)
  function automatic int period_len();
    int ticks;
    if (m_ctr) ticks = (m_top == 0) ? 1 : 2 * m_top;
    else       ticks = m_top + 1;
    return ticks * (1 << m_sel);
  endfunction

  // predicts the cycle after the coming edge, pushes it, then waits one cycle
  task automatic step(input string tag);
    logic [3:0] eo;
    bit epe = 1'b0;
    bit est = 1'b0;
    int t, v, c;
    bit pol, act;
    if (!m_run) begin
      if (start) begin m_run = 1'b1; m_pend = 1'b0; m_rel = 0; model_load(); end
    end else begin
      m_rel++;
      if (stop_req) m_pend = 1'b1;
      if (m_rel == period_len()) begin
        epe = 1'b1;
        if (m_pend) begin m_run = 1'b0; est = 1'b1; end
        else begin model_load(); m_rel = 0; end
      end
    end
    t = m_rel / (1 << m_sel);
    v = (m_ctr && t > m_top) ? 2 * m_top - t : t;
    for (int ch = 0; ch < 4; ch++) begin
      c   = int'(m_words[ch*16 +: 15]);
      pol = m_words[ch*16 + 15];
      act = m_run && (c != 0) && ((c >= m_top) || (v < c));
      eo[ch] = act ^ pol;
    end
    q_val.push_back({est, epe, eo});
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic run_case(input logic [2:0] sel, input bit ctr, input logic [14:0] top,
                          input logic [63:0] words, input int n_steps, input int stop_at,
                          input int stop2_at, input int restart_at, input int chg_at,
                          input logic [14:0] top2, input logic [63:0] words2, input string tag);
    prescale_sel = sel; center_mode = ctr; top_value = top; cmp_words = words;
    for (int k = 0; k < n_steps; k++) begin
      start    = (k == 0) || (k == restart_at);
      stop_req = (k == stop_at) || (k == stop2_at);
      if (k == chg_at) begin top_value = top2; cmp_words = words2; end
      step(tag);
    end
    start = 1'b0; stop_req = 1'b0;
  endtask

  // monitor: compares the scoreboard queue against the ports after each edge
  initial begin
    logic [5:0] e;
    string tg;
    forever begin
      @(posedge clk); #2;
      if (q_val.size() > 0) begin
        e  = q_val.pop_front();
        tg = q_tag.pop_front();
        check({stopped, period_end, pwm_out} === e, tg, {stopped, period_end, pwm_out}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check({stopped, period_end, pwm_out} === 6'b0, "R1 reset state", {stopped, period_end, pwm_out}, 6'b0);
    @(negedge clk);
    // R3 R5 R6 R8 R9: sawtooth, top 9, polarity, zero and saturated compares
    run_case(3'd0, 1'b0, 15'd9, 64'h0009_0000_8004_0004, 36, 25, -1, -1, -1,
             15'd0, 64'h0, "R3 R5 R6 R8 R9");
    // R2 R4 R7: triangle, divide by 4, words and top changed mid-period
    run_case(3'd2, 1'b1, 15'd5, 64'h8000_0005_8003_0002, 70, 50, -1, -1, 13,
             15'd3, 64'h0004_8003_0002_0001, "R2 R4 R7");
    // R10 R11: stop on the boundary edge, start while running, stop while idle
    run_case(3'd0, 1'b0, 15'd4, 64'h8002_0004_0001_8003, 18, 10, 14, 3, -1,
             15'd0, 64'h0, "R10 R11");
    // R12: top of zero, sawtooth divide by 2 then triangle
    run_case(3'd1, 1'b0, 15'd0, 64'h0001_8000_0000_0001, 9, 5, -1, -1, -1,
             15'd0, 64'h0, "R12 sawtooth");
    run_case(3'd0, 1'b1, 15'd0, 64'h0001_8000_0000_0001, 6, 3, -1, -1, -1,
             15'd0, 64'h0, "R12 triangle");
    repeat (3) step("R9 idle");
    @(posedge clk); #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule